// File: doc/BRIEF.md
# Calendar Alarm and Watchdog Supervisor

This block sits beside a calendar clock and watches it. It holds five alarm fields (seconds, minutes, hours, date, month) and compares them against the clock's current values once per second. Each field carries its own repeat-mask bit, so the alarm can fire every second, every minute, every hour, every day or every month. It also runs a programmable watchdog timer that the host must service by writing the watchdog byte. A steering bit sends watchdog expiry either to a held reset output or to the shared interrupt line.

The host uses a sixteen-byte register bus. Events are recorded in a flag byte. Reading that byte returns the flags and clears the alarm and watchdog bits. The battery-low bit is a live copy of an input and is not cleared by the read.

The watchdog is a three-state machine. WD_OFF waits with a zero multiplier. WD_RUN counts fast ticks. WD_HOLD drives the reset output. The transitions are:
- WD_OFF to WD_RUN on a write with a nonzero multiplier.
- WD_RUN to WD_RUN on expiry with interrupt steering, and the count restarts.
- WD_RUN to WD_HOLD on expiry with reset steering.
- WD_HOLD to WD_RUN after the hold count of fast ticks.
- Any state to WD_RUN or WD_OFF on a watchdog write, chosen by whether the written multiplier is zero.

Top module: `alarm_wdog_sup`

## Requirements
- R1: After reset the flag byte reads 00h (with battery-low low), all configuration bytes read 00h, and `irq` and `wd_rst` are low.
- R2: Bytes at addresses 2h to 7h read back what was last written. Addresses 1h and 8h to Fh read 00h. `rdata` is loaded at the clock edge that samples `cs` and `re` high.
- R3: Alarm byte layout: seconds at 2h, minutes at 3h, hours at 4h, date at 5h, month at 6h. Bits 6:0 hold the compare value and bit 7 is the repeat mask. When `sec_tick` is high and every field matches, flag byte bit 6 sets at that edge and `irq` goes high.
- R4: The alarm is evaluated only in `sec_tick` cycles. A matching time without a tick sets no flag, and a match held for many cycles sets the flag once per tick.
- R5: A field whose mask bit 7 is set matches any current value. A field whose mask bit is clear and whose value differs blocks the alarm.
- R6: Watchdog byte 7h layout: bit 7 is steering (1 selects reset), bits 6:2 are the multiplier M, and bits 1:0 are the resolution R. Expiry happens on the M*4^R-th `fast_tick` after the last write to 7h, and it sets flag byte bit 7 at that edge.
- R7: A multiplier of zero disables the watchdog. No expiry occurs, however many fast ticks arrive.
- R8: Any write to 7h restarts the timeout count from zero.
- R9: With reset steering, `wd_rst` rises at the expiry edge and stays high for exactly HOLD_TICKS fast ticks. The watchdog does not raise `irq`.
- R10: With interrupt steering, expiry raises `irq` and `wd_rst` stays low.
- R11: A read of 0h returns the flags and clears bits 7 and 6, so `irq` falls unless a new event sets a flag at that same edge. A new event wins over the clear.
- R12: Flag byte bit 4 reflects `bat_low` at the read and is never cleared by reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Register bus select |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cur_sec | input | 7 | Current seconds |
| cur_min | input | 7 | Current minutes |
| cur_hour | input | 7 | Current hours |
| cur_date | input | 7 | Current date |
| cur_month | input | 7 | Current month |
| sec_tick | input | 1 | One-second tick, one cycle wide |
| fast_tick | input | 1 | Watchdog time base tick, one cycle wide |
| bat_low | input | 1 | Battery-low status |
| irq | output | 1 | Interrupt output |
| wd_rst | output | 1 | Watchdog reset output |

## Verification
Flags, `irq` and `wd_rst` change at the same edge that samples the causing tick or write. `rdata` is loaded at the edge that samples the read strobe. So every stimulus is driven on a falling edge and held across exactly one rising edge, and results are sampled on the following falling edge. Watchdog checks count fast-tick pulses explicitly. Each test samples one pulse before the expected timeout and again right at it, so a count that is off by one tick shows up. The hold length is checked the same way at HOLD_TICKS-1 and at HOLD_TICKS pulses.

// File: rtl/sup_pkg.sv
package sup_pkg;

    localparam logic [3:0] ADR_FLAGS = 4'h0;
    localparam logic [3:0] ADR_ALM0  = 4'h2;
    localparam logic [3:0] ADR_WDOG  = 4'h7;
    localparam int         NUM_FLD   = 5;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_HOLD = 2'd2
    } wd_state_t;

endpackage

// File: rtl/sup_alarm_match.sv
module sup_alarm_match #(
    parameter int FW = 7,
    parameter int NF = 5
) (
    input  logic                 sec_tick,
    input  logic [NF-1:0][FW:0]  cfg,
    input  logic [NF-1:0][FW-1:0] now,
    output logic                 hit
);
    logic [NF-1:0] fld_ok;

    for (genvar g = 0; g < NF; g++) begin : g_fld
        assign fld_ok[g] = cfg[g][FW] || (cfg[g][FW-1:0] == now[g]);
    end

    assign hit = sec_tick && (&fld_ok);
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int MULT_W     = 5,
    parameter int RES_W      = 2,
    parameter int RES_STEP   = 2,
    parameter int HOLD_TICKS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fast_tick,
    input  logic                       wr_en,
    input  logic [MULT_W+RES_W:0]      wdata,
    output logic [MULT_W+RES_W:0]      cfg,
    output logic                       expire,
    output logic                       rst_out
);
    localparam int SPAN_W = MULT_W + RES_STEP * ((1 << RES_W) - 1);
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
    localparam int CNT_W  = (SPAN_W > HOLD_W) ? SPAN_W : HOLD_W;
    localparam int CW     = MULT_W + RES_W + 1;

    wd_state_t          state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   limit;
    logic [MULT_W-1:0]  cfg_mult, new_mult;
    logic [RES_W-1:0]   cfg_res;
    logic               steer_rst, at_limit, hold_done;

    assign cfg_mult  = cfg[CW-2 -: MULT_W];
    assign cfg_res   = cfg[RES_W-1:0];
    assign steer_rst = cfg[CW-1];
    assign new_mult  = wdata[CW-2 -: MULT_W];
    assign limit     = CNT_W'(cfg_mult) << (RES_STEP * cfg_res);
    assign at_limit  = (state == WD_RUN) && fast_tick && (cnt == limit - 1'b1);
    assign hold_done = (state == WD_HOLD) && fast_tick && (cnt == CNT_W'(HOLD_TICKS - 1));

    // next-state logic
    always_comb begin
        nxt = state;
        if (wr_en) begin
            nxt = (new_mult == '0) ? WD_OFF : WD_RUN;
        end else begin
            unique case (state)
                WD_OFF:  nxt = WD_OFF;
                WD_RUN:  if (at_limit) nxt = steer_rst ? WD_HOLD : WD_RUN;
                WD_HOLD: if (hold_done) nxt = WD_RUN;
                default: nxt = WD_OFF;
            endcase
        end
    end

    // state register, count and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_OFF;
            cnt   <= '0;
            cfg   <= '0;
        end else begin
            state <= nxt;
            if (wr_en) begin
                cfg <= wdata;
                cnt <= '0;
            end else if (at_limit || hold_done) begin
                cnt <= '0;
            end else if (fast_tick && state != WD_OFF) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        expire  = at_limit && !wr_en;
        rst_out = (state == WD_HOLD);
    end

    assert_off_when_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mult == '0) |-> (state == WD_OFF));

    assert_rst_from_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(expire));

    assert_rst_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> $past(fast_tick || wr_en));
endmodule

// File: rtl/alarm_wdog_sup.sv
module alarm_wdog_sup
    import sup_pkg::*;
#(
    parameter int FIELD_W    = 7,
    parameter int MULT_W     = 5,
    parameter int RES_W      = 2,
    parameter int RES_STEP   = 2,
    parameter int HOLD_TICKS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               we,
    input  logic               re,
    input  logic [3:0]         addr,
    input  logic [FIELD_W:0]   wdata,
    output logic [FIELD_W:0]   rdata,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_date,
    input  logic [FIELD_W-1:0] cur_month,
    input  logic               sec_tick,
    input  logic               fast_tick,
    input  logic               bat_low,
    output logic               irq,
    output logic               wd_rst
);
    localparam int DW = FIELD_W + 1;

    logic [NUM_FLD-1:0][DW-1:0]      alm_q;
    logic [NUM_FLD-1:0][FIELD_W-1:0] now;
    logic [DW-1:0]                   wd_cfg, rd_val;
    logic wr, rd, wd_wr, flag_rd, alarm_hit, wd_expire;
    logic alm_flag, wd_flag;

    assign wr      = cs && we;
    assign rd      = cs && re;
    assign wd_wr   = wr && (addr == ADR_WDOG);
    assign flag_rd = rd && (addr == ADR_FLAGS);
    assign now     = {cur_month, cur_date, cur_hour, cur_min, cur_sec};

    sup_alarm_match #(.FW(FIELD_W), .NF(NUM_FLD)) u_match (
        .sec_tick (sec_tick),
        .cfg      (alm_q),
        .now      (now),
        .hit      (alarm_hit)
    );

    sup_wdog #(
        .MULT_W(MULT_W), .RES_W(RES_W), .RES_STEP(RES_STEP), .HOLD_TICKS(HOLD_TICKS)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .wr_en     (wd_wr),
        .wdata     (wdata),
        .cfg       (wd_cfg),
        .expire    (wd_expire),
        .rst_out   (wd_rst)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_q <= '0;
        end else begin
            for (int i = 0; i < NUM_FLD; i++) begin
                if (wr && addr == ADR_ALM0 + 4'(i)) alm_q[i] <= wdata;
            end
        end
    end

    // event flags: a new event wins over the read clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_flag <= 1'b0;
            wd_flag  <= 1'b0;
        end else begin
            if (alarm_hit)    alm_flag <= 1'b1;
            else if (flag_rd) alm_flag <= 1'b0;
            if (wd_expire)    wd_flag  <= 1'b1;
            else if (flag_rd) wd_flag  <= 1'b0;
        end
    end

    always_comb begin
        rd_val = '0;
        if (addr == ADR_FLAGS) begin
            rd_val[DW-1] = wd_flag;
            rd_val[DW-2] = alm_flag;
            rd_val[DW-4] = bat_low;
        end else if (addr == ADR_WDOG) begin
            rd_val = wd_cfg;
        end else if (addr >= ADR_ALM0 && addr < ADR_ALM0 + 4'(NUM_FLD)) begin
            rd_val = alm_q[3'(addr - ADR_ALM0)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_val;
    end

    assign irq = alm_flag || (wd_flag && !wd_cfg[DW-1]);

    assert_alarm_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(sec_tick));

    assert_wd_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> wd_flag);

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !alarm_hit) |=> !alm_flag);
endmodule

// File: tb/test_alarm_wdog_sup.sv
module test_alarm_wdog_sup;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       cs = 0, we = 0, re = 0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [6:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_date = 0, cur_month = 0;
    logic       sec_tick = 0, fast_tick = 0, bat_low = 0;
    logic       irq, wd_rst;

    int total = 0;
    int bad = 0;
    localparam int HOLD = 8;

    always #2.5 clk = ~clk;

    alarm_wdog_sup i_alarm_wdog_sup (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .re(re), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_date(cur_date), .cur_month(cur_month),
        .sec_tick(sec_tick), .fast_tick(fast_tick), .bat_low(bat_low),
        .irq(irq), .wd_rst(wd_rst)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        cs = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; we = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        cs = 1; re = 1; addr = a;
        @(negedge clk);
        d = rdata;
        cs = 0; re = 0;
    endtask

    task automatic fast_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            fast_tick = 1;
            @(negedge clk);
            fast_tick = 0;
        end
    endtask

    task automatic sec_pulse();
        sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
    endtask

    task automatic set_time(input logic [6:0] s, mi, h, dt, mo);
        cur_sec = s; cur_min = mi; cur_hour = h; cur_date = dt; cur_month = mo;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 wd_rst", {7'b0, wd_rst}, 8'h00);
        bus_read(4'h0, d); chk("R1 flags", d, 8'h00);
        bus_read(4'h7, d); chk("R1 wdog cfg", d, 8'h00);
        bus_read(4'h4, d); chk("R1 alarm cfg", d, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        for (int i = 2; i <= 6; i++) bus_write(4'(i), 8'(8'h40 + i));
        bus_write(4'h7, 8'h83);
        for (int i = 2; i <= 6; i++) begin
            bus_read(4'(i), d); chk("R2 alarm readback", d, 8'(8'h40 + i));
        end
        bus_read(4'h7, d); chk("R2 wdog readback", d, 8'h83);
        bus_read(4'h1, d); chk("R2 unused 1h", d, 8'h00);
        bus_read(4'h9, d); chk("R2 unused 9h", d, 8'h00);
        bus_write(4'h7, 8'h00);
    endtask

    task automatic t_alarm();
        logic [7:0] d;
        bus_write(4'h2, 8'h15); bus_write(4'h3, 8'h30); bus_write(4'h4, 8'h08);
        bus_write(4'h5, 8'h12); bus_write(4'h6, 8'h03);
        set_time(7'h15, 7'h30, 7'h08, 7'h12, 7'h03);
        repeat (4) @(negedge clk);
        chk("R4 no tick no irq", {7'b0, irq}, 8'h00);
        sec_pulse();
        chk("R3 irq on match", {7'b0, irq}, 8'h01);
        bus_read(4'h0, d); chk("R3 alarm flag", d, 8'h40);
        chk("R11 irq cleared", {7'b0, irq}, 8'h00);
        repeat (5) @(negedge clk);
        bus_read(4'h0, d); chk("R4 held match sets once", d, 8'h00);
        // R11: event at the same edge as the clearing read wins
        sec_pulse();
        sec_tick = 1;
        bus_read(4'h0, d);
        sec_tick = 0;
        chk("R11 read sees old flag", d, 8'h40);
        chk("R11 new event kept", {7'b0, irq}, 8'h01);
        bus_read(4'h0, d); chk("R11 cleared after", d, 8'h40);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        cur_month = 7'h04;
        sec_pulse();
        bus_read(4'h0, d); chk("R5 mismatch blocks", d, 8'h00);
        bus_write(4'h6, 8'h83);
        sec_pulse();
        bus_read(4'h0, d); chk("R5 masked month", d, 8'h40);
        bus_write(4'h3, 8'h80); bus_write(4'h4, 8'h80); bus_write(4'h5, 8'h80);
        set_time(7'h15, 7'h59, 7'h23, 7'h01, 7'h0c);
        sec_pulse();
        bus_read(4'h0, d); chk("R5 per-minute alarm", d, 8'h40);
        cur_sec = 7'h16;
        sec_pulse();
        bus_read(4'h0, d); chk("R5 seconds differ", d, 8'h00);
        for (int i = 2; i <= 6; i++) bus_write(4'(i), 8'h7f);
    endtask

    task automatic t_wd_reset();
        logic [7:0] d;
        bus_write(4'h7, 8'h8D);   // steer reset, M=3, R=1 -> 12 ticks
        fast_pulses(11);
        chk("R6 before timeout", {7'b0, wd_rst}, 8'h00);
        fast_pulses(1);
        chk("R9 wd_rst at timeout", {7'b0, wd_rst}, 8'h01);
        chk("R9 no irq", {7'b0, irq}, 8'h00);
        bus_read(4'h0, d); chk("R6 wd flag", d, 8'h80);
        fast_pulses(HOLD - 1);
        chk("R9 still held", {7'b0, wd_rst}, 8'h01);
        fast_pulses(1);
        chk("R9 released", {7'b0, wd_rst}, 8'h00);
        bus_write(4'h7, 8'h00);
    endtask

    task automatic t_wd_kick();
        logic [7:0] d;
        bus_write(4'h7, 8'h08);   // steer irq, M=2, R=0
        fast_pulses(1);
        bus_write(4'h7, 8'h08);
        fast_pulses(1);
        chk("R8 restart delays expiry", {7'b0, irq}, 8'h00);
        fast_pulses(1);
        chk("R10 irq on expiry", {7'b0, irq}, 8'h01);
        chk("R10 no reset", {7'b0, wd_rst}, 8'h00);
        bus_read(4'h0, d); chk("R10 wd flag", d, 8'h80);
        chk("R11 irq cleared", {7'b0, irq}, 8'h00);
        bus_write(4'h7, 8'h06);   // M=1, R=2 -> 16 ticks
        fast_pulses(15);
        chk("R6 resolution early", {7'b0, irq}, 8'h00);
        fast_pulses(1);
        chk("R6 resolution expiry", {7'b0, irq}, 8'h01);
        bus_read(4'h0, d);
        bus_write(4'h7, 8'h03);   // M=0 disables
        fast_pulses(300);
        chk("R7 disabled irq", {7'b0, irq}, 8'h00);
        chk("R7 disabled rst", {7'b0, wd_rst}, 8'h00);
        bus_read(4'h0, d); chk("R7 no flag", d, 8'h00);
    endtask

    task automatic t_battery();
        logic [7:0] d;
        bat_low = 1;
        bus_read(4'h0, d); chk("R12 battery bit", d, 8'h10);
        bus_read(4'h0, d); chk("R12 not cleared", d, 8'h10);
        chk("R12 no irq", {7'b0, irq}, 8'h00);
        bat_low = 0;
        bus_read(4'h0, d); chk("R12 follows input", d, 8'h00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_alarm();
        t_mask();
        t_wd_reset();
        t_wd_kick();
        t_battery();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule